// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This block keeps the interrupt state of a serial port. It has five live status levels from the receive and transmit paths and five single-cycle event pulses: overrun, framing error, parity error, receive timeout and modem status change. Each source has one bit in a sticky status register. A bit is set when its source is active and stays set until software clears it. A mask register selects which sticky bits may raise the single level-sensitive interrupt line.

Software reaches the block through a 32-bit register bus that has no wait states. Writes take effect on the clock edge, and reads are combinational from the address. The mask is never written directly. It is changed only through a write-one-to-set register and a write-one-to-clear register, so one write never disturbs mask bits owned by other code. The sticky status register is cleared by writing ones to it.

Top module: `uirq_unit`

## Requirements
- R1: After a synchronous active-low reset, the mask and the sticky status are both zero and `irq_o` is low.
- R2: A live status bit sets its sticky bit at the next clock edge. The bit positions are 0 = receive trigger reached, 1 = receive empty, 2 = receive full, 3 = transmit empty and 4 = transmit full. The sticky bit stays set after the live input drops.
- R3: An event pulse sets its sticky bit at the next clock edge. The bit positions are 5 = overrun, 6 = framing error, 7 = parity error, 8 = receive timeout and 9 = modem status change.
- R4: A write to byte offset 0x08 ORs bits [9:0] of the written data into the mask.
- R5: A write to byte offset 0x0C clears every mask bit written as one and leaves the other mask bits unchanged.
- R6: Offset 0x10 reads the mask in bits [9:0]. A write to 0x10 leaves the mask and the status unchanged.
- R7: Offset 0x14 reads the sticky status in bits [9:0]. A write to 0x14 clears every status bit written as one.
- R8: If a source sets a sticky bit in the same cycle that a write to 0x14 clears it, the bit stays set.
- R9: `irq_o` is high exactly when some bit is set in both the mask and the sticky status.
- R10: Read data bits [31:10] are always zero. A read of any offset other than 0x10 and 0x14 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| live_stat | input | 5 | Live receive and transmit status levels (sticky bits 4:0) |
| evt_pulse | input | 5 | Error and event pulses (sticky bits 9:5) |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit bus, an 8-bit address, five live sources and five event sources. With ten sticky bits, every source position is one that software can see. The upper read bits [31:10] are then always padding, so a write of all ones to the mask and status registers shows that stray high data bits are ignored. At this size a short table can drive each source, each mask operation and the same-cycle set and clear collision on the bits that feed the interrupt.

// File: rtl/uirq_pkg.sv
// Package uirq_pkg
// Shared constants for the serial port interrupt unit: the default widths
// and the byte offsets of the registers. The offsets are fixed by the
// software view, and every other module takes them from here.
package uirq_pkg;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_ADDR_W = 8;
    localparam int DEF_N_LIVE = 5;
    localparam int DEF_N_EVT  = 5;

    localparam logic [7:0] OFS_MASK_SET = 8'h08;
    localparam logic [7:0] OFS_MASK_CLR = 8'h0C;
    localparam logic [7:0] OFS_MASK_RD  = 8'h10;
    localparam logic [7:0] OFS_STATUS   = 8'h14;

    // Write strobes decoded from one bus write
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic stat_clr;
    } wr_strobe_t;

endpackage

// File: rtl/uirq_decode.sv
// Module uirq_decode
// Decodes the register bus. It turns a write into at most one strobe and
// forms the read data from the mask and status registers.
// Assumes: a write lasts exactly one cycle, reads have no side effect,
// and ADDR_W is at least 8 bits.
module uirq_decode
    import uirq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int N_SRC  = DEF_N_LIVE + DEF_N_EVT
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [N_SRC-1:0]  mask_q,
    input  logic [N_SRC-1:0]  stat_q,
    output wr_strobe_t        wstb,
    output logic [N_SRC-1:0]  wbits,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - N_SRC;

    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_MASK_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_MASK_CLR);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK_RD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

    logic [N_SRC-1:0] rd_low;

    // Write strobes: one per writable register, gated by the write enable
    always_comb begin
        wstb.mask_set = bus_we && (bus_addr == A_SET);
        wstb.mask_clr = bus_we && (bus_addr == A_CLR);
        wstb.stat_clr = bus_we && (bus_addr == A_STAT);
    end

    // Only the low bits of the write data reach the registers
    assign wbits = bus_wdata[N_SRC-1:0];

    // Read multiplexer: mask and status are readable, everything else is zero
    always_comb begin
        if (bus_addr == A_MASK) begin
            rd_low = mask_q;
        end else if (bus_addr == A_STAT) begin
            rd_low = stat_q;
        end else begin
            rd_low = '0;
        end
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[DATA_W-1:N_SRC];
            assign bus_rdata = {{PAD_W{1'b0}}, rd_low};
        end else begin : g_nopad
            assign bus_rdata = rd_low;
        end
    endgenerate

endmodule

// File: rtl/uirq_mask.sv
// Module uirq_mask
// Holds the interrupt mask. Software changes it only through the set and
// clear strobes. There is no direct write path.
// Assumes: the set and clear strobes are never active together, because
// they come from different offsets of one bus.
module uirq_mask #(
    parameter int N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] mask_q
);

    // Mask register: OR in on set, AND out on clear, zero on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_stb) begin
            mask_q <= mask_q | wbits;
        end else if (clr_stb) begin
            mask_q <= mask_q & ~wbits;
        end
    end

endmodule

// File: rtl/uirq_sticky.sv
// Module uirq_sticky
// The sticky status register, one flop per source, built in a generate
// loop. A source sets its bit. A software write-one-to-clear resets it,
// and a set in the same cycle wins over the clear.
// Assumes: src is already merged (live levels and event pulses).
module uirq_sticky #(
    parameter int N_SRC = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic             clr_stb,
    input  logic [N_SRC-1:0] wbits,
    output logic [N_SRC-1:0] stat_q
);

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_bit
            logic clr_i;
            assign clr_i = clr_stb && wbits[i];

            // One sticky bit: set has priority over clear
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[i] <= 1'b0;
                end else if (src[i]) begin
                    stat_q[i] <= 1'b1;
                end else if (clr_i) begin
                    stat_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/uirq_unit.sv
// Module uirq_unit (top)
// Interrupt status and mask unit of a serial port. It merges the live
// status levels and the event pulses into the sticky status register,
// holds the mask, decodes the register bus and drives one level
// interrupt that is the OR of the masked sticky bits.
// Assumes: all inputs are synchronous to clk, and reset is synchronous
// and active low.
module uirq_unit
    import uirq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int N_LIVE = DEF_N_LIVE,
    parameter int N_EVT  = DEF_N_EVT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_LIVE-1:0] live_stat,
    input  logic [N_EVT-1:0]  evt_pulse,
    output logic              irq_o
);

    localparam int N_SRC = N_LIVE + N_EVT;

    wr_strobe_t       wstb;
    logic [N_SRC-1:0] wbits;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] src_all;

    // Source vector: events sit above the live status bits
    assign src_all = {evt_pulse, live_stat};

    uirq_decode #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .N_SRC (N_SRC)
    ) u_decode (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .mask_q   (mask_q),
        .stat_q   (stat_q),
        .wstb     (wstb),
        .wbits    (wbits),
        .bus_rdata(bus_rdata)
    );

    uirq_mask #(
        .N_SRC(N_SRC)
    ) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_stb(wstb.mask_set),
        .clr_stb(wstb.mask_clr),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    uirq_sticky #(
        .N_SRC(N_SRC)
    ) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .src    (src_all),
        .clr_stb(wstb.stat_clr),
        .wbits  (wbits),
        .stat_q (stat_q)
    );

    // Interrupt line: any bit that is both masked-in and set
    assign irq_o = |(mask_q & stat_q);

endmodule

// File: rtl/uirq_unit_chk.sv
// Module uirq_unit_chk
// Property checker for uirq_unit, attached to it with bind. It relates the
// bus writes and the source inputs to the mask and status flops on the
// following cycle.
module uirq_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int N_LIVE = 5,
    parameter int N_EVT  = 5
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_we,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [N_LIVE-1:0]         live_stat,
    input logic [N_EVT-1:0]          evt_pulse,
    input logic                      irq_o,
    input logic [N_LIVE+N_EVT-1:0]   mask_q,
    input logic [N_LIVE+N_EVT-1:0]   stat_q
);

    localparam int N_SRC = N_LIVE + N_EVT;

    logic wr_set, wr_clr, wr_ro;
    assign wr_set = bus_we && (bus_addr == ADDR_W'(8'h08));
    assign wr_clr = bus_we && (bus_addr == ADDR_W'(8'h0C));
    assign wr_ro  = bus_we && (bus_addr == ADDR_W'(8'h10));

    // R1: the first cycle after reset shows cleared state
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_q == '0 && stat_q == '0 && !irq_o));

    generate
        for (genvar i = 0; i < N_LIVE; i++) begin : g_live
            // R2: a live level sets its sticky bit
            assert_live_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
                live_stat[i] |=> stat_q[i]);
        end
        for (genvar j = 0; j < N_EVT; j++) begin : g_evt
            // R3 and R8: an event pulse sets its bit, even under a clear
            assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
                evt_pulse[j] |=> stat_q[N_LIVE+j]);
        end
    endgenerate

    // R4: after a set write, every written one is in the mask
    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));

    // R5: after a clear write, no written one is left in the mask
    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_q & $past(bus_wdata[N_SRC-1:0])) == '0));

    // R6: a write to the read-only mask offset changes nothing
    assert_mask_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ro |=> $stable(mask_q));

    // R9: a raised interrupt needs both a mask bit and a status bit
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($countones(mask_q) > 0 && $countones(stat_q) > 0));

    // R10: read data above the source bits is always zero
    assert_rdata_pad_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:N_SRC] == '0);

endmodule

bind uirq_unit uirq_unit_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .N_LIVE(N_LIVE),
    .N_EVT (N_EVT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .live_stat(live_stat),
    .evt_pulse(evt_pulse),
    .irq_o    (irq_o),
    .mask_q   (mask_q),
    .stat_q   (stat_q)
);

// File: tb/sim_uirq_unit.sv
// Bench for uirq_unit. A vector table drives one cycle of stimulus per
// entry, then reads the mask and the status back over the bus. Directed
// tests for reset, unmapped reads and padding follow.
module sim_uirq_unit;

    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [4:0]  live;
        logic [4:0]  evt;
        logic [9:0]  emask;
        logic [9:0]  estat;
        logic        eirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0,          5'b00001, 5'b00000, 10'h000, 10'h001, 1'b0, 4'd2},  // R2 set
        '{1'b0, 8'h00, 32'h0,          5'b00000, 5'b00000, 10'h000, 10'h001, 1'b0, 4'd2},  // R2 hold
        '{1'b1, 8'h08, 32'h00000001,   5'b00000, 5'b00000, 10'h001, 10'h001, 1'b1, 4'd4},  // R4, R9
        '{1'b1, 8'h14, 32'h00000001,   5'b00000, 5'b00000, 10'h001, 10'h000, 1'b0, 4'd7},  // R7
        '{1'b0, 8'h00, 32'h0,          5'b00000, 5'b00001, 10'h001, 10'h020, 1'b0, 4'd3},  // R3 overrun
        '{1'b0, 8'h00, 32'h0,          5'b01000, 5'b10000, 10'h001, 10'h228, 1'b0, 4'd3},  // R3 modem + R2
        '{1'b1, 8'h08, 32'h00000200,   5'b00000, 5'b00000, 10'h201, 10'h228, 1'b1, 4'd4},  // R4
        '{1'b1, 8'h0C, 32'h00000001,   5'b00000, 5'b00000, 10'h200, 10'h228, 1'b1, 4'd5},  // R5
        '{1'b1, 8'h10, 32'h000003FF,   5'b00000, 5'b00000, 10'h200, 10'h228, 1'b1, 4'd6},  // R6
        '{1'b1, 8'h14, 32'h00000200,   5'b00000, 5'b10000, 10'h200, 10'h228, 1'b1, 4'd8},  // R8 event
        '{1'b1, 8'h14, 32'hFFFFFFFF,   5'b00000, 5'b00000, 10'h200, 10'h000, 1'b0, 4'd7},  // R7 all
        '{1'b1, 8'h0C, 32'h00000200,   5'b00000, 5'b00000, 10'h000, 10'h000, 1'b0, 4'd5},  // R5
        '{1'b1, 8'h08, 32'h00000004,   5'b00110, 5'b00000, 10'h004, 10'h006, 1'b1, 4'd9},  // R9
        '{1'b1, 8'h14, 32'h00000002,   5'b00010, 5'b00000, 10'h004, 10'h006, 1'b1, 4'd8}   // R8 live
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [4:0]  live_stat = 5'b0;
    logic [4:0]  evt_pulse = 5'b0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uirq_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .live_stat(live_stat),
        .evt_pulse(evt_pulse),
        .irq_o    (irq_o)
    );

    task automatic check(input int req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_state(input int req, input logic [9:0] em, input logic [9:0] es,
                              input logic ei);
        logic [31:0] d;
        rd(8'h10, d);
        check(req, "mask read", d, {22'b0, em});
        rd(8'h14, d);
        check(req, "status read", d, {22'b0, es});
        check(req, "irq", {31'b0, irq_o}, {31'b0, ei});
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1: outputs during and right after reset
        rst_n = 1'b1;
        @(negedge clk);
        read_state(1, 10'h000, 10'h000, 1'b0);

        // Vector table: one stimulus cycle, then a readback
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            bus_we    = VEC[k].we;
            bus_addr  = VEC[k].addr;
            bus_wdata = VEC[k].wdata;
            live_stat = VEC[k].live;
            evt_pulse = VEC[k].evt;
            @(negedge clk);
            bus_we    = 1'b0;
            live_stat = 5'b0;
            evt_pulse = 5'b0;
            read_state(int'(VEC[k].req), VEC[k].emask, VEC[k].estat, VEC[k].eirq);
        end

        // R10: unmapped and write-only offsets read zero
        rd(8'h08, d);
        check(10, "read of set offset", d, 32'h0);
        rd(8'h00, d);
        check(10, "read of unmapped offset", d, 32'h0);

        // R4 and R10: high data bits written to the set register are dropped
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'hFFFFFC00;
        @(negedge clk);
        bus_we = 1'b0;
        rd(8'h10, d);
        check(4, "mask after high-bit set", d, 32'h00000004);

        // R9: the same status with its mask bit removed drops irq
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h00000004;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        check(9, "irq after unmask", {31'b0, irq_o}, 32'h0);

        // R1: a reset in the middle clears the mask and the status
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h000003FF;
        @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_state(1, 10'h000, 10'h000, 1'b0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule